// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block is a synthesizable behavioural model of a synchronous static memory in which every access moves a fixed group of four data words. The memory runs on a beat-rate clock. An internal phase flag splits each beat pair into a positive beat and a complementary beat, which stand for the two edges of one period of the input clock. A command is a one-cycle active-low load strobe together with a word address and a direction bit. It is taken only on a positive beat. The four data beats that follow cover the next two clock periods.

The low two bits of the load address seed a two-bit counter. The counter steps linearly and wraps modulo four, so a burst never leaves its aligned group of four words. Write data comes with per-lane active-low byte selects, and these are sampled with each data beat. Read data comes back after a fixed latency of one clock period, with a valid flag and an output enable on each beat. A load that arrives while the previous command still holds the command slot is dropped and reported on an error output.

Top module: `qburst_sram`

## Requirements
- R1: Loads are sampled only on positive beats (pos_beat = 1). pos_beat is high in the first cycle after reset and then toggles every cycle. A low ld_n on a complementary beat has no effect and raises no error.
- R2: For a load accepted in cycle n, rw = 1 makes the burst a read and rw = 0 makes it a write.
- R3: A write accepted in cycle n stores the wdata presented in cycles n+2, n+3, n+4 and n+5, one word per beat.
- R4: bsel_n[i] is active low and is sampled in the same cycle as its data beat. It guards bits [9i+8:9i] for i = 0..3. A lane whose select is high keeps its stored value.
- R5: A read accepted in cycle n drives rdata with rvalid = 1 and oe = 1 in cycles n+2 to n+5, and the first beat falls on a positive beat.
- R6: The beat addresses of a burst are {addr[7:2], (addr[1:0]+k) mod 4} for k = 0..3. With start offset 2, for example, the order is 2, 3, 0, 1.
- R7: In cycles without a read beat, oe = 0, rvalid = 0 and rdata = 0.
- R8: After an accepted load in cycle n, a load in cycle n+2 is ignored and ld_err is high in cycle n+3 only. A load in cycle n+4 is accepted, and its data beats follow the previous burst with no gap.
- R9: After reset, ld_err and rvalid are 0 and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | Direction: 1 read, 0 write |
| addr | input | 8 | Word address of the burst |
| wdata | input | 36 | Write data for the current beat |
| bsel_n | input | 4 | Active-low byte-lane write selects |
| pos_beat | output | 1 | High on positive-clock beats |
| rdata | output | 36 | Read data beat |
| rvalid | output | 1 | Read data valid on this beat |
| oe | output | 1 | Output enable; low means the bus would float |
| ld_err | output | 1 | A load was dropped in the previous cycle |

## Verification
The assertions watch the beat structure on every cycle. They check that the phase alternates, that an error only follows a low strobe on a positive beat, that error pulses are isolated, that each read run starts on a positive beat and lasts whole bursts, and that the outputs come out of reset quiet. Whether the returned words are right can only be shown by the bench's scenarios, which run against a behavioural model of the memory. This covers the wrapped address order, byte-lane masking within a burst, the drop-and-flag of an early load and the gapless follow-on burst, and the fact that a strobe on a complementary beat is ignored.

// File: rtl/qburst_pkg.sv
package qburst_pkg;

    localparam int BURST_LEN = 4;
    localparam int OFF_W     = $clog2(BURST_LEN);
    // Cycles after an accepted load during which a new load is refused.
    localparam int GUARD_CYC = 3;
    localparam int GUARD_W   = $clog2(GUARD_CYC + 1);

    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [GUARD_W-1:0] guard_t;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;

    typedef struct packed {
        logic vld;
        dir_e dir;
    } ctl_t;

    // Linear burst offset, wrapping inside the aligned group.
    function automatic off_t wrap_off(off_t start, off_t beat);
        return off_t'(start + beat);
    endfunction

    function automatic logic is_last(off_t beat);
        return beat == off_t'(BURST_LEN - 1);
    endfunction

endpackage

// File: rtl/qburst_loadctl.sv
module qburst_loadctl
    import qburst_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    output logic          pos_beat,
    output ctl_t          cmd,
    output logic [AW-1:0] cmd_addr,
    output logic          ld_err
);

    logic   ph_pos;
    guard_t guard;
    logic   req, accept, refuse;

    assign req    = ph_pos && !ld_n;
    assign accept = req && (guard == '0);
    assign refuse = req && (guard != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_pos <= 1'b1;
            guard  <= '0;
            cmd    <= '{vld: 1'b0, dir: DIR_WR};
            ld_err <= 1'b0;
        end else begin
            ph_pos  <= !ph_pos;
            ld_err  <= refuse;
            cmd.vld <= accept;
            if (accept) begin
                guard   <= guard_t'(GUARD_CYC);
                cmd.dir <= rw ? DIR_RD : DIR_WR;
            end else if (guard != '0) begin
                guard <= guard - guard_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_addr <= '0;
        end else if (accept) begin
            cmd_addr <= addr;
        end
    end

    assign pos_beat = ph_pos;

endmodule

// File: rtl/qburst_beatseq.sv
module qburst_beatseq
    import qburst_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          cmd,
    input  logic [AW-1:0] cmd_addr,
    output logic          act,
    output dir_e          dir,
    output logic [AW-1:0] cur_addr
);

    localparam int HW = AW - OFF_W;

    logic [HW-1:0] base_hi;
    off_t          start;
    off_t          beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= 1'b0;
            dir     <= DIR_WR;
            base_hi <= '0;
            start   <= '0;
            beat    <= '0;
        end else if (cmd.vld) begin
            act     <= 1'b1;
            dir     <= cmd.dir;
            base_hi <= cmd_addr[AW-1:OFF_W];
            start   <= cmd_addr[OFF_W-1:0];
            beat    <= '0;
        end else if (act) begin
            if (is_last(beat)) begin
                act <= 1'b0;
            end
            beat <= beat + off_t'(1);
        end
    end

    assign cur_addr = {base_hi, wrap_off(start, beat)};

endmodule

// File: rtl/qburst_array.sv
module qburst_array #(
    parameter int DW = 36,
    parameter int NB = 4,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] adr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] bsel_n,
    output logic [DW-1:0] rd
);

    localparam int LW    = DW / NB;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) begin
                    store[i] <= '0;
                end
            end else if (we && !bsel_n[g]) begin
                store[adr] <= wdata[g*LW +: LW];
            end
        end

        assign rd[g*LW +: LW] = store[adr];
    end

endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
    import qburst_pkg::*;
#(
    parameter int DW = 36,
    parameter int NB = 4,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] bsel_n,
    output logic          pos_beat,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          oe,
    output logic          ld_err
);

    ctl_t          cmd;
    logic [AW-1:0] cmd_addr;
    logic          act;
    dir_e          dir;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] arr_rd;
    logic          rd_beat;

    qburst_loadctl #(.AW(AW)) u_ld (
        .clk      (clk),
        .rst      (rst),
        .ld_n     (ld_n),
        .rw       (rw),
        .addr     (addr),
        .pos_beat (pos_beat),
        .cmd      (cmd),
        .cmd_addr (cmd_addr),
        .ld_err   (ld_err)
    );

    qburst_beatseq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cmd_addr (cmd_addr),
        .act      (act),
        .dir      (dir),
        .cur_addr (cur_addr)
    );

    qburst_array #(.DW(DW), .NB(NB), .AW(AW)) u_arr (
        .clk    (clk),
        .rst    (rst),
        .we     (act && (dir == DIR_WR)),
        .adr    (cur_addr),
        .wdata  (wdata),
        .bsel_n (bsel_n),
        .rd     (arr_rd)
    );

    assign rd_beat = act && (dir == DIR_RD);
    assign rvalid  = rd_beat;
    assign oe      = rd_beat;
    assign rdata   = rd_beat ? arr_rd : '0;

endmodule

// File: rtl/qburst_sram_chk.sv
module qburst_sram_chk (
    input logic clk,
    input logic rst,
    input logic ld_n,
    input logic pos_beat,
    input logic rvalid,
    input logic ld_err
);

    logic       seen;
    logic [1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            rcnt <= '0;
        end else begin
            seen <= 1'b1;
            rcnt <= rvalid ? rcnt + 2'd1 : 2'd0;
        end
    end

    // R1: phase alternates each cycle once out of reset
    a_r1_phase_alt: assert property (@(posedge clk) disable iff (rst)
        seen |-> (pos_beat != $past(pos_beat)));

    // R1 / R8: an error only follows a low strobe on a positive beat
    a_r1_err_on_pos: assert property (@(posedge clk) disable iff (rst)
        ld_err |-> (seen && $past(pos_beat) && !$past(ld_n)));

    // R8: dropped loads cannot be flagged on adjacent cycles
    a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
        ld_err |=> !ld_err);

    // R5: every read burst starts on a positive beat
    a_r5_start_pos: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rcnt == 2'd0) |-> pos_beat);

    // R5: read bursts are never cut short
    a_r5_whole_burst: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rcnt != 2'd3) |=> rvalid);

    // R9: quiet outputs in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (pos_beat && !rvalid && !ld_err));

endmodule

bind qburst_sram qburst_sram_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .ld_n     (ld_n),
    .pos_beat (pos_beat),
    .rvalid   (rvalid),
    .ld_err   (ld_err)
);

// File: tb/qburst_sram_tb.sv
`timescale 1ns/100ps
module qburst_sram_tb_top;

    localparam int DW = 36;
    localparam int NB = 4;
    localparam int AW = 8;
    localparam int LW = DW / NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_n = 1'b1;
    logic          rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] bsel_n = '1;
    logic          pos_beat, rvalid, oe, ld_err;
    logic [DW-1:0] rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_acc = -100;
    string cur_tag = "R6";

    logic [DW-1:0] mmem [int];
    int    rd_at  [int];
    string rtag_at[int];
    int    wr_at  [int];
    bit    err_at [int];
    string itag_at[int];

    always #2.5 clk = ~clk;

    qburst_sram #(.DW(DW), .NB(NB), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata(wdata), .bsel_n(bsel_n), .pos_beat(pos_beat),
        .rdata(rdata), .rvalid(rvalid), .oe(oe), .ld_err(ld_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mread(int a);
        return mmem.exists(a) ? mmem[a] : '0;
    endfunction

    function automatic int baddr(int a, int k);
        return (a & ~3) | ((a + k) & 3);
    endfunction

    // reference model: compare this cycle, then fold in this cycle's inputs
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_rv;
            string itag;
            exp_rv = rd_at.exists(cyc);
            itag = (cyc == 0) ? "R9" : (itag_at.exists(cyc) ? itag_at[cyc] : "R7");
            chk((cyc == 0) ? "R9" : "R1", "pos_beat", DW'(pos_beat), DW'((cyc % 2) == 0));
            chk(exp_rv ? "R5" : itag, "rvalid", DW'(rvalid), DW'(exp_rv));
            chk(exp_rv ? "R5" : itag, "oe", DW'(oe), DW'(exp_rv));
            if (exp_rv)
                chk(rtag_at[cyc], "rdata", rdata, mread(rd_at[cyc]));
            else
                chk(itag, "rdata idle", rdata, '0);
            chk((cyc == 0) ? "R9" : "R8", "ld_err", DW'(ld_err), DW'(err_at.exists(cyc)));

            if (wr_at.exists(cyc)) begin
                logic [DW-1:0] v;
                v = mread(wr_at[cyc]);
                for (int i = 0; i < NB; i++)
                    if (!bsel_n[i]) v[i*LW +: LW] = wdata[i*LW +: LW];
                mmem[wr_at[cyc]] = v;
            end

            if (!ld_n) begin
                if ((cyc % 2) != 0) begin
                    for (int k = 2; k < 6; k++) itag_at[cyc + k] = "R1";
                end else if (cyc - last_acc >= 4) begin
                    last_acc = cyc;
                    for (int k = 0; k < 4; k++) begin
                        if (rw) begin
                            rd_at[cyc + 2 + k]   = baddr(int'(addr), k);
                            rtag_at[cyc + 2 + k] = cur_tag;
                        end else begin
                            wr_at[cyc + 2 + k] = baddr(int'(addr), k);
                        end
                    end
                end else begin
                    err_at[cyc + 1] = 1'b1;
                end
            end
            cyc++;
        end
    end

    task automatic step(input logic l, input logic r, input logic [AW-1:0] a,
                        input logic [NB-1:0] s);
        ld_n   = l;
        rw     = r;
        addr   = a;
        bsel_n = s;
        wdata  = DW'({$urandom(), $urandom()});
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(2);                                        // c0-c1: reset state R9
        cur_tag = "R2/R3";
        step(1'b0, 1'b0, 8'h10, '0);                    // c2: write 0x10
        idle(1);                                        // c3
        cur_tag = "R8";
        step(1'b0, 1'b1, 8'h40, '0);                    // c4: too early, dropped (R8)
        idle(1);                                        // c5
        cur_tag = "R2/R3";
        step(1'b0, 1'b1, 8'h10, '0);                    // c6: read 0x10, back-to-back
        idle(3);                                        // c7-c9
        cur_tag = "R4";
        step(1'b0, 1'b0, 8'h22, '0);                    // c10: write offset 2 (R6)
        idle(1);                                        // c11
        step(1'b1, 1'b0, '0, 4'b0000);                  // c12: all lanes
        step(1'b1, 1'b0, '0, 4'b1010);                  // c13: lanes 0,2
        cur_tag = "R4/R6";
        step(1'b0, 1'b1, 8'h21, 4'b0101);               // c14: lanes 1,3; read offset 1
        step(1'b1, 1'b0, '0, 4'b1111);                  // c15: no lanes
        idle(3);                                        // c16-c18
        step(1'b0, 1'b1, 8'h10, '1);                    // c19: complementary beat, ignored (R1)
        idle(4);                                        // c20-c23
        cur_tag = "R9";
        step(1'b0, 1'b1, 8'h80, '0);                    // c24: unwritten word reads zero
        idle(5);                                        // c25-c29
        cur_tag = "R6";
        step(1'b0, 1'b0, 8'hFF, '0);                    // c30: write offset 3, wraps
        idle(5);                                        // c31-c35
        step(1'b0, 1'b1, 8'hFC, '0);                    // c36: read the group aligned
        idle(12);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule